// File: doc/BRIEF.md
# Configurable Compressor Slice

This block is one slice of a programmable multi-input adder fabric. Sixteen operand bits enter through a per-bit enable mask. Any operand bit except bit 0 can be given double weight (rank 1), and each rank-1 bit drives two taps of a 31-input population counter. The 5-bit count is then combined with two carry-in rows from the previous slice. This happens in a row of 5:3 column counters, then a row of 3:2 compressors, then a carry-propagate adder.

Static configuration controls four things. It selects either the carry-save pair or the adder sum as the slice result. It sets the result width (the maximum output rank) to 1, 2 or 3 bits. It can break the inter-slice chain by forcing both carry-in rows to zero. It can bypass the result register. The part of the total above the result width leaves on two carry-out rows in the same cycle. Their weight is 2^m relative to this slice, so the fabric places the next slice m columns higher.

A mapping tool fills in the configuration, and the configuration is held constant while the fabric operates. The weighted total is T = count + carry-in-sum row + carry-in-carry row. The slice conserves T exactly whenever T < 2^(CW+1), which is 128 for the default CW = 6.

Top module: `cmp_slice`

## Requirements
- R1: An operand bit i contributes to the count only when both op_i[i] and cfg_en_i[i] are 1. Bit 0 always has weight 1. Bit i ≥ 1 has weight 2 when cfg_dbl_i[i] is 1 and weight 1 otherwise. With cfg_en_i all zero the count is 0.
- R2: The slice total is T = count + ci_s_i + ci_c_i, all as unsigned integers.
- R3: With cfg_cpa_i = 1 the result is res_s_o = T mod 2^m, res_c_o = 0, co_s_o = T >> m and co_c_o = 0.
- R4: With cfg_cpa_i = 0 the result is a carry-save pair with res_s_o < 2^m, res_c_o < 2^m and res_s_o + res_c_o + 2^m·(co_s_o + co_c_o) = T.
- R5: With cfg_brk_i = 1, ci_s_i and ci_c_i have no effect and T equals the count.
- R6: cfg_morc_i sets m as follows: 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 3, and 2'b00 gives 1. Result bits at positions m and above are 0.
- R7: co_s_o and co_c_o follow the operand, configuration and carry-in inputs in the same cycle, with no clock edge needed.
- R8: With cfg_bypass_i = 0, res_s_o and res_c_o show the result sampled at the previous rising clock edge. While rst_n is low they are 0.
- R9: With cfg_bypass_i = 1, res_s_o and res_c_o follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| op_i | input | 16 | Operand bits |
| cfg_en_i | input | 16 | Per-bit enable mask |
| cfg_dbl_i | input | 15 | Rank-1 (double weight) select for bits 15..1 |
| cfg_brk_i | input | 1 | Force both carry-in rows to zero |
| cfg_cpa_i | input | 1 | 1: adder sum result, 0: carry-save pair |
| cfg_bypass_i | input | 1 | 1: bypass the result register |
| cfg_morc_i | input | 2 | Result width code (maximum output rank) |
| ci_s_i | input | 6 | Carry-in sum row from the previous slice |
| ci_c_i | input | 6 | Carry-in carry row from the previous slice |
| res_s_o | output | 3 | Result (adder sum or carry-save sum bits) |
| res_c_o | output | 3 | Carry-save carry bits of the result (0 in adder mode) |
| co_s_o | output | 6 | Carry-out sum row, weight 2^m |
| co_c_o | output | 6 | Carry-out carry row, weight 2^m |

## Verification
Each possible internal fault shows up as a visible break in the relation between the result field, the carry-outs weighted by 2^m, and the rank-weighted operand sum plus carry-ins. A wrong tap in the counter, a lost column in either compressor row, or an adder carry error shows in that same cycle on the carry-out rows. It shows on the result field in the same cycle when the register is bypassed, or one clock later when it is not. A result bit left set above the chosen width, or a carry-in that leaks through while the chain is broken, is also caught by the next sample of the ports. The bench compares every applied vector against a weighted sum that it computes on its own, covering both result modes, all four width codes, masks, rank mixes, chain breaks and register timing.

// File: rtl/cmp_slice_pkg.sv
package cmp_slice_pkg;

    // Result field width: the largest selectable output rank count.
    localparam int RW = 3;

    typedef struct packed {
        logic [RW-1:0] s;
        logic [RW-1:0] c;
    } cs_res_t;

    // Population count of five column bits (a 5:3 counter).
    function automatic logic [2:0] count5(input logic [4:0] v);
        logic [2:0] n;
        n = '0;
        for (int k = 0; k < 5; k++) begin
            n = n + {2'b00, v[k]};
        end
        return n;
    endfunction

    // Width code to rank count; code 0 is treated as one rank.
    function automatic logic [1:0] norm_width(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

    function automatic logic [RW-1:0] rank_mask(input logic [1:0] m);
        unique case (m)
            2'd1:    return 3'b001;
            2'd2:    return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/cs_wcount.sv
module cs_wcount #(
    parameter int NIN  = 16,
    parameter int CNTW = 5
) (
    input  logic [NIN-1:0]  op_i,
    input  logic [NIN-1:0]  en_i,
    input  logic [NIN-1:1]  dbl_i,
    output logic [CNTW-1:0] cnt_o
);
    localparam int NTAP = 2 * NIN - 1;

    logic [NIN-1:0]  live;
    logic [NTAP-1:0] tap;

    assign live   = op_i & en_i;
    assign tap[0] = live[0];

    // A rank-1 bit occupies two taps of the wide counter.
    generate
        for (genvar i = 1; i < NIN; i++) begin : g_tap
            assign tap[2*i-1] = live[i];
            assign tap[2*i]   = live[i] & dbl_i[i];
        end
    endgenerate

    always_comb begin
        cnt_o = '0;
        for (int k = 0; k < NTAP; k++) begin
            cnt_o = cnt_o + CNTW'(tap[k]);
        end
    end

endmodule

// File: rtl/cs_reduce.sv
module cs_reduce
    import cmp_slice_pkg::*;
#(
    parameter int CW = 6,
    localparam int TW = CW + 2
) (
    input  logic [CW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    input  logic [CW-1:0] c_i,
    output logic [TW-1:0] s_o,
    output logic [TW-1:0] c_o,
    output logic [TW-1:0] sum_o
);
    logic [TW-1:0] row0, row1, row2;

    // 5:3 column counters: three live inputs per column, two tied low.
    generate
        for (genvar j = 0; j < CW; j++) begin : g_col53
            logic [2:0] k;
            assign k         = count5({2'b00, a_i[j], b_i[j], c_i[j]});
            assign row0[j]   = k[0];
            assign row1[j+1] = k[1];
            assign row2[j+2] = k[2];
        end
    endgenerate

    assign row0[TW-1:CW] = '0;
    assign row1[0]       = 1'b0;
    assign row1[TW-1]    = 1'b0;
    assign row2[1:0]     = '0;

    // 3:2 compressor row; the top column never produces a carry.
    assign s_o    = row0 ^ row1 ^ row2;
    assign c_o[0] = 1'b0;
    generate
        for (genvar j = 0; j < TW - 1; j++) begin : g_col32
            assign c_o[j+1] = (row0[j] & row1[j]) | (row0[j] & row2[j]) | (row1[j] & row2[j]);
        end
    endgenerate

    // Carry-propagate adder.
    assign sum_o = s_o + c_o;

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_slice_pkg::*;
#(
    parameter int NIN = 16,
    parameter int CW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] op_i,
    input  logic [NIN-1:0] cfg_en_i,
    input  logic [NIN-1:1] cfg_dbl_i,
    input  logic           cfg_brk_i,
    input  logic           cfg_cpa_i,
    input  logic           cfg_bypass_i,
    input  logic [1:0]     cfg_morc_i,
    input  logic [CW-1:0]  ci_s_i,
    input  logic [CW-1:0]  ci_c_i,
    output logic [RW-1:0]  res_s_o,
    output logic [RW-1:0]  res_c_o,
    output logic [CW-1:0]  co_s_o,
    output logic [CW-1:0]  co_c_o
);
    localparam int CNTW = $clog2(2 * NIN);
    localparam int TW   = CW + 2;

    logic [CNTW-1:0] cnt;
    logic [CW-1:0]   cin_s, cin_c;
    logic [TW-1:0]   row_s, row_c, sum;
    logic [1:0]      m;
    logic [RW-1:0]   msk;
    cs_res_t         sel, st_d, st_q;

    // Upper part of a TW-bit row, seen from a slice m ranks higher.
    function automatic logic [CW-1:0] upper(input logic [TW-1:0] v, input logic [1:0] r);
        unique case (r)
            2'd1:    return v[CW:1];
            2'd2:    return v[CW+1:2];
            default: return {1'b0, v[CW+1:3]};
        endcase
    endfunction

    cs_wcount #(.NIN(NIN), .CNTW(CNTW)) i_count (
        .op_i  (op_i),
        .en_i  (cfg_en_i),
        .dbl_i (cfg_dbl_i),
        .cnt_o (cnt)
    );

    assign cin_s = cfg_brk_i ? '0 : ci_s_i;
    assign cin_c = cfg_brk_i ? '0 : ci_c_i;

    cs_reduce #(.CW(CW)) i_reduce (
        .a_i   (CW'(cnt)),
        .b_i   (cin_s),
        .c_i   (cin_c),
        .s_o   (row_s),
        .c_o   (row_c),
        .sum_o (sum)
    );

    assign m   = norm_width(cfg_morc_i);
    assign msk = rank_mask(m);

    always_comb begin
        if (cfg_cpa_i) begin
            sel.s  = sum[RW-1:0] & msk;
            sel.c  = '0;
            co_s_o = upper(sum, m);
            co_c_o = '0;
        end else begin
            sel.s  = row_s[RW-1:0] & msk;
            sel.c  = row_c[RW-1:0] & msk;
            co_s_o = upper(row_s, m);
            co_c_o = upper(row_c, m);
        end
    end

    // Result register, two-process form.
    always_comb begin
        st_d = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_s_o = cfg_bypass_i ? sel.s : st_q.s;
    assign res_c_o = cfg_bypass_i ? sel.c : st_q.c;

    // Checker helpers: independent sums of the slice boundary.
    logic [TW:0] chk_total;
    logic [31:0] chk_out;
    always_comb begin
        chk_total = (TW+1)'(cnt) + (TW+1)'(cin_s) + (TW+1)'(cin_c);
        chk_out   = 32'(sel.s) + 32'(sel.c) + ((32'(co_s_o) + 32'(co_c_o)) << m);
    end

    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_i == '0) |-> (cnt == '0)); // R1

    AST_ROWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_s) + 32'(row_c)) == (32'(cnt) + 32'(cin_s) + 32'(cin_c))); // R2

    AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_total < (TW+1)'(2 ** (CW + 1))) |-> (chk_out == 32'(chk_total))); // R4

    AST_NARROW_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass_i && cfg_morc_i <= 2'd1) |-> (res_s_o[RW-1:1] == '0 && res_c_o[RW-1:1] == '0)); // R6

    AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass_i && $past(rst_n)) |-> (res_s_o == $past(sel.s) && res_c_o == $past(sel.c))); // R8

    AST_BYPASS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass_i |-> (res_s_o == sel.s && res_c_o == sel.c)); // R9

endmodule

// File: tb/test_cmp_slice.sv
module test_cmp_slice;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op, en, dbl;
    logic        brk, cpa, byp;
    logic [1:0]  morc;
    logic [5:0]  ci_s, ci_c;
    logic [2:0]  res_s, res_c;
    logic [5:0]  co_s, co_c;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cmp_slice i_cmp_slice (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .cfg_en_i     (en),
        .cfg_dbl_i    (dbl[15:1]),
        .cfg_brk_i    (brk),
        .cfg_cpa_i    (cpa),
        .cfg_bypass_i (byp),
        .cfg_morc_i   (morc),
        .ci_s_i       (ci_s),
        .ci_c_i       (ci_c),
        .res_s_o      (res_s),
        .res_c_o      (res_c),
        .co_s_o       (co_s),
        .co_c_o       (co_c)
    );

    typedef struct packed {
        logic [15:0] op;
        logic [15:0] en;
        logic [15:0] dbl;
        logic [5:0]  cs;
        logic [5:0]  cc;
        logic        cpa;
        logic [1:0]  morc;
        logic [7:0]  t;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'hFFFF, 16'hFFFF, 16'hFFFE, 6'd0,  6'd0,  1'b1, 2'd3, 8'd31},
        '{16'hFFFF, 16'hFFFF, 16'h0000, 6'd0,  6'd0,  1'b1, 2'd1, 8'd16},
        '{16'h00FF, 16'h0F0F, 16'h0000, 6'd5,  6'd3,  1'b0, 2'd2, 8'd12},
        '{16'h8001, 16'hFFFF, 16'h8000, 6'd40, 6'd47, 1'b1, 2'd2, 8'd90},
        '{16'hAAAA, 16'hFFFF, 16'hFFFE, 6'd1,  6'd0,  1'b0, 2'd3, 8'd17},
        '{16'h0001, 16'h0000, 16'h0000, 6'd0,  6'd0,  1'b1, 2'd1, 8'd0},
        '{16'h0003, 16'hFFFF, 16'h0002, 6'd0,  6'd0,  1'b1, 2'd0, 8'd3}
    };

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Rank-weighted total from the requirements (R1, R2, R5).
    function automatic int model(input logic [15:0] o, input logic [15:0] e, input logic [15:0] d,
                                 input int cs, input int cc, input logic b);
        int t = 0;
        for (int i = 0; i < 16; i++) begin
            if (o[i] && e[i]) t += (i > 0 && d[i]) ? 2 : 1;
        end
        if (!b) t += cs + cc;
        return t;
    endfunction

    task automatic check_out(input int t, input logic c, input logic [1:0] code, input string req);
        int m = (code == 2'd0) ? 1 : int'(code);
        if (c) begin
            check(int'(res_s), t % (1 << m), {req, " R3 sum"});
            check(int'(res_c), 0, {req, " R3 carry field"});
            check(int'(co_s), t >> m, {req, " R3 carry-out"});
            check(int'(co_c), 0, {req, " R3 carry-out row"});
        end else begin
            check(int'(res_s) + int'(res_c) + ((int'(co_s) + int'(co_c)) << m), t, {req, " R4 conserve"});
            check(int'(res_s < (1 << m) && res_c < (1 << m)), 1, {req, " R6 width"});
        end
    endtask

    task automatic drive(input logic [15:0] o, input logic [15:0] e, input logic [15:0] d,
                         input logic [5:0] cs, input logic [5:0] cc, input logic b,
                         input logic c, input logic [1:0] code, input logic y);
        op = o; en = e; dbl = d; ci_s = cs; ci_c = cc;
        brk = b; cpa = c; morc = code; byp = y;
    endtask

    initial begin : wd
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        drive(16'hFFFF, 16'hFFFF, 16'h0000, 6'd3, 6'd3, 1'b0, 1'b1, 2'd3, 1'b0);
        repeat (3) @(negedge clk);
        check(int'(res_s), 0, "R8 reset sum field");
        check(int'(res_c), 0, "R8 reset carry field");
        rst_n = 1'b1;

        // Vector table through the registered path.
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            drive(VECS[v].op, VECS[v].en, VECS[v].dbl, VECS[v].cs, VECS[v].cc,
                  1'b0, VECS[v].cpa, VECS[v].morc, 1'b0);
            @(negedge clk);
            check(model(VECS[v].op, VECS[v].en, VECS[v].dbl, int'(VECS[v].cs), int'(VECS[v].cc), 1'b0),
                  int'(VECS[v].t), "R1 R2 table model");
            check_out(int'(VECS[v].t), VECS[v].cpa, VECS[v].morc, $sformatf("R1 R2 R6 vector %0d", v));
        end

        // R5: chain break ignores both carry-in rows.
        @(negedge clk);
        drive(16'hFFFF, 16'hFFFF, 16'h0000, 6'd30, 6'd30, 1'b1, 1'b1, 2'd3, 1'b0);
        @(negedge clk);
        check(int'(res_s), 0, "R5 break result");
        check(int'(co_s), 2, "R5 break carry-out");

        // R8: register holds the previous value until the next edge.
        @(negedge clk);
        drive(16'h0007, 16'hFFFF, 16'h0000, 6'd0, 6'd0, 1'b0, 1'b1, 2'd3, 1'b0);
        @(negedge clk);
        check(int'(res_s), 3, "R8 settled value");
        drive(16'h001F, 16'hFFFF, 16'h0000, 6'd0, 6'd0, 1'b0, 1'b1, 2'd3, 1'b0);
        #2;
        check(int'(res_s), 3, "R8 held before edge");
        @(negedge clk);
        check(int'(res_s), 5, "R8 updated after edge");

        // R9 and R7: bypass and carry-outs react without an edge.
        drive(16'h003F, 16'hFFFF, 16'h0000, 6'd0, 6'd0, 1'b0, 1'b1, 2'd2, 1'b1);
        #2;
        check(int'(res_s), 2, "R9 bypass result");
        check(int'(co_s), 1, "R7 same-cycle carry-out");

        // Random configurations through both paths.
        for (int n = 0; n < 300; n++) begin
            logic [15:0] o, e, d;
            logic [5:0]  cs, cc;
            logic        b, c, y;
            logic [1:0]  code;
            o = 16'($urandom); e = 16'($urandom); d = 16'($urandom);
            cs = 6'($urandom % 48); cc = 6'($urandom % 48);
            b = 1'($urandom); c = 1'($urandom); y = 1'($urandom);
            code = 2'($urandom);
            @(negedge clk);
            drive(o, e, d, cs, cc, b, c, code, y);
            @(negedge clk);
            check_out(model(o, e, d, int'(cs), int'(cc), b), c, code, "R1 R2 R5 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule